// File: doc/BRIEF.md
# Smart Card Initial Character Detector

This block sits on the single-wire I/O line of a smart card interface and receives characters sent by the card. Its main job is to find the initial character of the answer-to-reset. Once the host arms detection, the block frames the next character and checks it against the two legal initial-character line patterns. From the one that matches, it learns whether the card uses direct or inverse convention. Every later character is decoded with the convention it learned.

Each character on the line is ten bits: a start bit, eight data bits and a parity bit. Timing comes from a sample tick that runs at a fixed number of ticks per etu.

Every character is handed on with a one-cycle strobe, even one that was rejected. The detect bit clears only on a valid initial character. If the detect bit is still set after a strobe, the host knows the character was not a valid initial character.

A bad character can be reported in one of two ways:
- With error signalling enabled, the block pulls the line low during the guard time.
- With it disabled, the block raises a parity-error flag instead.

Top module: `scd_ts_detect`

## Requirements
- R1: After reset, `armed`, `conv_inv`, `byte_vld`, `parity_err` and `io_drive_low` are all 0 (0 in `conv_inv` means direct convention).
- R2: A one-cycle pulse on `arm` sets `armed`, and `armed` stays set until a valid initial character is received.
- R3: While armed, a character whose line levels encode 0x3B in direct convention clears `armed`, sets `conv_inv` to 0 and is delivered as 0x3B. Direct convention means line high = logic 1 and data bits sent LSB first. Parity is even over the data and parity bits.
- R4: While armed, a character whose line levels encode 0x3F in inverse convention clears `armed`, sets `conv_inv` to 1 and is delivered as 0x3F. Inverse convention means line low = logic 1 and data bits sent MSB first. Parity is even over the logical data and parity bits.
- R5: When not armed, each character is decoded with the stored convention and delivered on `byte_data` with a one-cycle `byte_vld` strobe.
- R6: While armed, a character that matches neither initial pattern leaves `armed` and `conv_inv` unchanged. It is still delivered, decoded with the stored convention, and it counts as a character error.
- R7: With `nack_en` high, a character error (a parity error, or a mismatch while armed) produces an error signal on the line and leaves `parity_err` low. A good character never produces an error signal.
- R8: With `nack_en` low, a character error raises `parity_err` for the cycle of its `byte_vld` strobe, and the line is not driven.
- R9: The error signal drives `io_drive_low` high starting 10.5 etu after the start-bit edge, plus at most the input synchronizer and one tick of detection latency. It holds for exactly one etu.
- R10: A low level on the line that is high again at the middle of the first etu is ignored: there is no strobe and no drive, and the next real character is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_tick | input | 1 | Sample tick, SUBT ticks per etu |
| io_in | input | 1 | Level of the card I/O line |
| arm | input | 1 | Pulse to arm initial-character detection |
| nack_en | input | 1 | Enables the error signal on the line for bad characters |
| io_drive_low | output | 1 | When high, the line is pulled low (error signal) |
| conv_inv | output | 1 | Convention: 0 direct, 1 inverse |
| armed | output | 1 | Detection still armed |
| byte_vld | output | 1 | One-cycle strobe for a received character |
| byte_data | output | 8 | Decoded character value |
| parity_err | output | 1 | Character error flag, valid with the strobe |

## Verification
The bench sends several kinds of character while armed:
- Invalid characters, with error signalling both enabled and disabled. A design that cleared the detect bit on any character would fail here. So would one that dropped the rejected byte, or one that reported a parity error and also signalled it on the line.
- Both initial patterns, starting from each stored convention. A design that used the wrong bit order or polarity for inverse convention would return the wrong byte value, or would fail to recognise 0x3F.

The bench also measures the error signal's start and length in clock cycles. A guard-time window that was off by half an etu would show up in those numbers. A glitch shorter than half an etu must not start a frame.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam logic [7:0] TS_DIRECT  = 8'h3B;
    localparam logic [7:0] TS_INVERSE = 8'h3F;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_DATA  = 2'd1,
        RX_GUARD = 2'd2
    } rx_state_e;

    // lvl[i] is the line level of the i-th data bit after the start bit
    typedef struct packed {
        logic [7:0] lvl;
        logic       par;
    } raw_frame_t;

    function automatic logic [7:0] bit_rev(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // Line levels a card would send for a byte in the given convention
    function automatic raw_frame_t encode_frame(input logic [7:0] b, input logic inv);
        raw_frame_t f;
        f.lvl = inv ? ~bit_rev(b) : b;
        f.par = inv ? ~(^b) : (^b);
        return f;
    endfunction

    function automatic logic [7:0] decode_frame(input raw_frame_t f, input logic inv);
        return inv ? bit_rev(~f.lvl) : f.lvl;
    endfunction

    function automatic logic parity_good(input raw_frame_t f, input logic inv);
        return inv ? (^{f.lvl, f.par}) : ~(^{f.lvl, f.par});
    endfunction

endpackage

// File: rtl/scd_rx.sv
module scd_rx
    import scd_pkg::*;
#(
    parameter int SUBT  = 8,
    parameter int SYNCN = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       samp_tick,
    input  logic       io_in,
    input  logic       nack_req,
    output raw_frame_t frame,
    output logic       frame_done,
    output logic       drive_low
);
    localparam int CDW  = $clog2(SUBT + 1);
    localparam int HALF = SUBT / 2;

    logic [SYNCN-1:0] sync_q;
    logic             io_s;
    rx_state_e        state;
    logic [CDW-1:0]   cd;
    logic [3:0]       bidx;

    assign io_s = sync_q[SYNCN-1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNCN-2:0], io_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            cd         <= '0;
            bidx       <= '0;
            frame      <= '0;
            frame_done <= 1'b0;
            drive_low  <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (samp_tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!io_s) begin
                            state <= RX_DATA;
                            cd    <= CDW'(HALF);
                            bidx  <= '0;
                        end
                    end
                    default: begin
                        if (cd == CDW'(1)) begin
                            cd   <= CDW'(SUBT);
                            bidx <= bidx + 4'd1;
                            case (bidx)
                                4'd0: if (io_s) state <= RX_IDLE;
                                4'd9: begin
                                    frame.par  <= io_s;
                                    frame_done <= 1'b1;
                                    state      <= RX_GUARD;
                                end
                                4'd10: drive_low <= nack_req;
                                4'd11: begin
                                    drive_low <= 1'b0;
                                    state     <= RX_IDLE;
                                end
                                default: frame.lvl <= {io_s, frame.lvl[7:1]};
                            endcase
                        end else begin
                            cd <= cd - CDW'(1);
                        end
                    end
                endcase
            end
        end
    end

    a_r9_drive_in_guard: assert property (@(posedge clk) disable iff (rst)
        drive_low |-> (state == RX_GUARD));
    a_r9_release_to_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_low) |-> (state == RX_IDLE));
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

endmodule

// File: rtl/scd_decide.sv
module scd_decide
    import scd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       nack_en,
    input  raw_frame_t frame,
    input  logic       frame_done,
    output logic       conv_inv,
    output logic       armed,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       parity_err,
    output logic       nack_req
);
    logic match_dir, match_inv, ts_ok, use_inv, err;

    always_comb begin
        match_dir = (frame == encode_frame(TS_DIRECT, 1'b0));
        match_inv = (frame == encode_frame(TS_INVERSE, 1'b1));
        ts_ok     = armed && (match_dir || match_inv);
        use_inv   = ts_ok ? match_inv : conv_inv;
        err       = armed ? !(match_dir || match_inv) : !parity_good(frame, conv_inv);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_inv   <= 1'b0;
            armed      <= 1'b0;
            byte_vld   <= 1'b0;
            byte_data  <= '0;
            parity_err <= 1'b0;
            nack_req   <= 1'b0;
        end else begin
            byte_vld   <= frame_done;
            parity_err <= frame_done && err && !nack_en;
            armed      <= arm || (armed && !(frame_done && ts_ok));
            if (frame_done) begin
                byte_data <= decode_frame(frame, use_inv);
                nack_req  <= err && nack_en;
                if (ts_ok) conv_inv <= match_inv;
            end
        end
    end

    a_r3_armed_clears_on_byte: assert property (@(posedge clk) disable iff (rst)
        $fell(armed) |-> (byte_vld && !parity_err));
    a_r4_conv_moves_with_byte: assert property (@(posedge clk) disable iff (rst)
        !$stable(conv_inv) |-> byte_vld);
    a_r7_flag_or_nack: assert property (@(posedge clk) disable iff (rst)
        !(parity_err && nack_req));
    a_r8_flag_with_strobe: assert property (@(posedge clk) disable iff (rst)
        parity_err |-> byte_vld);

endmodule

// File: rtl/scd_ts_detect.sv
module scd_ts_detect
    import scd_pkg::*;
#(
    parameter int SUBT  = 8,
    parameter int SYNCN = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       samp_tick,
    input  logic       io_in,
    input  logic       arm,
    input  logic       nack_en,
    output logic       io_drive_low,
    output logic       conv_inv,
    output logic       armed,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       parity_err
);
    raw_frame_t frame;
    logic       frame_done;
    logic       nack_req;

    scd_rx #(.SUBT(SUBT), .SYNCN(SYNCN)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .samp_tick  (samp_tick),
        .io_in      (io_in),
        .nack_req   (nack_req),
        .frame      (frame),
        .frame_done (frame_done),
        .drive_low  (io_drive_low)
    );

    scd_decide u_dec (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .nack_en    (nack_en),
        .frame      (frame),
        .frame_done (frame_done),
        .conv_inv   (conv_inv),
        .armed      (armed),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .parity_err (parity_err),
        .nack_req   (nack_req)
    );

endmodule

// File: tb/sim_scd_ts_detect.sv
module sim_scd_ts_detect;
    localparam int SUBT = 8;
    localparam int TDIV = 4;
    localparam int ETU  = SUBT * TDIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic samp_tick = 1'b0;
    logic card_line = 1'b1;
    logic arm = 1'b0;
    logic nack_en = 1'b0;
    logic io_in, io_drive_low, conv_inv, armed, byte_vld, parity_err;
    logic [7:0] byte_data;

    int n_tests = 0, n_fail = 0;
    int n_vld, rise_at, fall_at;
    logic [7:0] cap_data;
    logic cap_perr;
    int tcnt = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tcnt      <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        samp_tick <= (tcnt == TDIV - 1);
    end

    assign io_in = card_line & ~io_drive_low;

    scd_ts_detect #(.SUBT(SUBT)) u0 (
        .clk(clk), .rst(rst), .samp_tick(samp_tick), .io_in(io_in),
        .arm(arm), .nack_en(nack_en), .io_drive_low(io_drive_low),
        .conv_inv(conv_inv), .armed(armed), .byte_vld(byte_vld),
        .byte_data(byte_data), .parity_err(parity_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // short_low > 0: only a glitch of that many clocks, no frame
    task automatic run_frame(input logic [7:0] b, input logic inv, input logic badpar,
                             input int short_low);
        logic [7:0] lv;
        logic p;
        for (int i = 0; i < 8; i++) lv[i] = inv ? ~b[7-i] : b[i];
        p = inv ? ~(^b) : (^b);
        if (badpar) p = ~p;
        n_vld = 0; rise_at = -1; fall_at = -1; cap_data = 8'h00; cap_perr = 1'b0;
        for (int i = 0; i < 13 * ETU; i++) begin
            @(negedge clk);
            if (byte_vld) begin
                n_vld++;
                cap_data = byte_data;
                cap_perr = parity_err;
            end
            if (io_drive_low && rise_at < 0) rise_at = i;
            if (!io_drive_low && rise_at >= 0 && fall_at < 0) fall_at = i;
            if (short_low > 0) card_line = (i >= short_low);
            else begin
                int k;
                k = i / ETU;
                if (k == 0)      card_line = 1'b0;
                else if (k <= 8) card_line = lv[k-1];
                else if (k == 9) card_line = p;
                else             card_line = 1'b1;
            end
        end
        card_line = 1'b1;
    endtask

    task automatic check_nack(input string tag);
        chk(rise_at >= (21 * ETU) / 2 && rise_at <= (21 * ETU) / 2 + TDIV + 4,
            {tag, " nack start"}, rise_at, (21 * ETU) / 2);
        chk(fall_at - rise_at == ETU, {tag, " nack length"}, fall_at - rise_at, ETU);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!armed && !conv_inv && !byte_vld && !parity_err && !io_drive_low, "R1 reset",
            {armed, conv_inv, byte_vld, parity_err, io_drive_low}, 0);
    endtask

    task automatic t_arm;
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        repeat (3) @(negedge clk);
        chk(armed, "R2 arm sets", armed, 1);
    endtask

    task automatic t_armed_bad(input logic ne);
        nack_en = ne;
        run_frame(8'h55, 1'b0, 1'b0, 0);
        chk(n_vld == 1, "R6 rejected byte strobed", n_vld, 1);
        chk(cap_data == 8'h55, "R6 data", cap_data, 8'h55);
        chk(armed && !conv_inv, "R6 still armed", {armed, conv_inv}, 2'b10);
        if (ne) begin
            chk(!cap_perr, "R7 no flag with nack", cap_perr, 0);
            check_nack("R9");
        end else begin
            chk(cap_perr, "R8 flag", cap_perr, 1);
            chk(rise_at < 0, "R8 no drive", rise_at, -1);
        end
    endtask

    task automatic t_ts(input logic inv);
        nack_en = 1'b1;
        run_frame(inv ? 8'h3F : 8'h3B, inv, 1'b0, 0);
        if (inv) begin
            chk(cap_data == 8'h3F && n_vld == 1, "R4 data", cap_data, 8'h3F);
            chk(!armed && conv_inv, "R4 conv inverse", {armed, conv_inv}, 2'b01);
        end else begin
            chk(cap_data == 8'h3B && n_vld == 1, "R3 data", cap_data, 8'h3B);
            chk(!armed && !conv_inv, "R3 conv direct", {armed, conv_inv}, 2'b00);
        end
        chk(!cap_perr && rise_at < 0, "R7 good TS no error", {cap_perr, rise_at < 0}, 1);
    endtask

    task automatic t_byte(input logic [7:0] b, input logic inv);
        nack_en = 1'b1;
        run_frame(b, inv, 1'b0, 0);
        chk(n_vld == 1 && cap_data == b, "R5 decode", cap_data, b);
        chk(!cap_perr && rise_at < 0, "R7 good byte no nack", rise_at, -1);
        chk(conv_inv == inv && !armed, "R5 conv kept", conv_inv, inv);
    endtask

    task automatic t_parity(input logic [7:0] b, input logic inv, input logic ne);
        nack_en = ne;
        run_frame(b, inv, 1'b1, 0);
        chk(n_vld == 1, "R5 strobe on parity error", n_vld, 1);
        if (ne) begin
            chk(!cap_perr, "R7 no flag", cap_perr, 0);
            check_nack("R9 parity");
        end else begin
            chk(cap_perr, "R8 parity flag", cap_perr, 1);
            chk(rise_at < 0, "R8 line free", rise_at, -1);
        end
    endtask

    task automatic t_glitch;
        nack_en = 1'b1;
        run_frame(8'h00, 1'b0, 1'b0, ETU / 4);
        chk(n_vld == 0, "R10 glitch no strobe", n_vld, 0);
        chk(rise_at < 0, "R10 glitch no drive", rise_at, -1);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_arm();
        t_armed_bad(1'b0);
        t_armed_bad(1'b1);
        t_ts(1'b1);
        t_byte(8'hA5, 1'b1);
        t_parity(8'h6C, 1'b1, 1'b0);
        t_parity(8'h6C, 1'b1, 1'b1);
        t_arm();
        t_ts(1'b0);
        t_byte(8'hC4, 1'b0);
        t_glitch();
        t_byte(8'h17, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule